// File: doc/BRIEF.md
# Cell Sequence Header Checker

This block inspects the one-octet header that leads each 48-octet cell payload of a constant-bit-rate circuit stream. The header carries a four-bit sequence field (one indicator bit and a three-bit modulo-8 count) guarded by a three-bit cyclic code and an even-parity bit. For every header presented with a strobe, the checker decides whether the sequence field can be trusted. It repairs a single flipped bit when that is safe and rejects the header otherwise.

Error handling follows a two-state policy. While headers arrive clean, the block is in a repairing state, and one single-bit error is fixed and accepted. After any error it drops to a guarded state, where every damaged header is rejected until a clean one arrives. For accepted headers, the block also compares the count with the previous accepted count. It flags a break in continuity, which points to a lost or misinserted cell, and then resynchronises to the received value. A downstream payload handler uses the accept flag, the repaired fields and the continuity flag to decide what to do with the rest of the cell.

Top module: `aal1_sn_check`

## Requirements
- R1: Header bit layout: bit 7 is the indicator, bits 6:4 are the count (bit 6 most significant), and bits 3:1 are the remainder of bits 7:4 times x^3 divided by x^3+x+1, with bit 7 as the highest degree and bit 3 as the top remainder bit. Bit 0 makes the number of ones across all eight bits even.
- R2: Every output is registered. `o_stb` is `in_stb` delayed by exactly one clock. `o_ok`, `o_fixed` and `o_seq_err` are 0 in any cycle where `o_stb` is 0.
- R3: A header with zero syndrome and good parity is accepted with its fields unchanged (`o_ok`=1, `o_fixed`=0), and the block enters the repairing state from either state.
- R4: In the repairing state, a header with bad parity is treated as a single-bit error. A nonzero syndrome locates the flipped codeword bit, and a zero syndrome means the parity bit itself was flipped. The header is accepted with the repaired fields and `o_fixed`=1, and the block enters the guarded state.
- R5: A header with a nonzero syndrome and good parity is a multi-bit error. It is rejected (`o_ok`=0), and the block enters the guarded state.
- R6: In the guarded state, any header with a nonzero syndrome or bad parity is rejected, and the block stays guarded.
- R7: For an accepted header whose count differs from the previous accepted count plus one (modulo 8), `o_seq_err` is 1 for that one output cycle. The new count then becomes the reference. A wrap from 7 to 0 is continuous.
- R8: The first accepted header after reset raises no `o_seq_err`. Rejected headers neither raise `o_seq_err` nor change the reference count.
- R9: After reset, all outputs are 0, the block is in the repairing state, and no reference count is held.
- R10: `o_ind` and `o_cnt` show the fields of the last accepted header and hold through idle cycles and rejected headers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_stb | input | 1 | Header octet present this cycle |
| in_hdr | input | 8 | Received header octet |
| o_stb | output | 1 | Result for the previous-cycle header |
| o_ok | output | 1 | Header accepted |
| o_fixed | output | 1 | Accepted after a single-bit repair |
| o_ind | output | 1 | Repaired indicator bit of last accepted header |
| o_cnt | output | 3 | Repaired count of last accepted header |
| o_seq_err | output | 1 | Count discontinuity on this accepted header |

## Verification
The header stream is driven with clean codewords in running order, including the 7-to-0 wrap. It is also driven with every single-bit flip across all eight header positions, applied both in the repairing state and right after an error. This separates repair from rejection and shows the state change. Double-bit flips separate the multi-bit rejection from single-bit repair. Skipped and repeated counts, counts carried by rejected headers, and a reset in the middle of a stream show how the continuity reference is set and kept. A long random mix with idle gaps compares every output on every clock against a brute-force decoder, which finds the nearest valid codeword by trying each bit flip.

// File: rtl/aal1_sn_pkg.sv
package aal1_sn_pkg;

    localparam int SN_W   = 4;
    localparam int CNT_W  = SN_W - 1;
    localparam int CRC_W  = 3;
    localparam int CW_W   = SN_W + CRC_W;
    localparam int HDR_W  = CW_W + 1;

    typedef enum logic {
        MODE_REPAIR = 1'b0,
        MODE_GUARD  = 1'b1
    } sn_mode_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_SINGLE = 2'd1,
        ERR_MULTI  = 2'd2
    } err_class_e;

    typedef struct packed {
        sn_mode_e           mode;
        logic               stb;
        logic               ok;
        logic               fixed;
        logic               ind;
        logic [CNT_W-1:0]   cnt;
    } chk_state_t;

    typedef struct packed {
        logic               have_ref;
        logic [CNT_W-1:0]   last;
        logic               err;
    } seq_state_t;

    // Remainder of a codeword-width polynomial divided by the generator.
    function automatic logic [CRC_W-1:0] cw_remainder(input logic [CW_W-1:0] cw,
                                                      input logic [CRC_W:0]  gen);
        logic [CW_W-1:0] r;
        r = cw;
        for (int i = CW_W - 1; i >= CRC_W; i--) begin
            if (r[i]) r = r ^ (CW_W'(gen) << (i - CRC_W));
        end
        return r[CRC_W-1:0];
    endfunction

endpackage

// File: rtl/aal1_sn_decode.sv
module aal1_sn_decode
    import aal1_sn_pkg::*;
#(
    parameter logic [CRC_W:0] GEN_POLY = 4'b1011
) (
    input  logic [HDR_W-1:0] hdr,
    output err_class_e       cls,
    output logic [SN_W-1:0]  sn_fix
);

    logic [CRC_W-1:0] syn;
    logic             par_bad;
    logic [SN_W-1:0]  hit;

    assign syn     = cw_remainder(hdr[HDR_W-1 -: CW_W], GEN_POLY);
    assign par_bad = ^hdr;

    // One syndrome comparator per sequence-field bit; check-bit flips need no repair.
    for (genvar j = 0; j < SN_W; j++) begin : g_pos
        localparam logic [CRC_W-1:0] POS_SYN =
            cw_remainder(CW_W'(1) << (j + CRC_W), GEN_POLY);
        assign hit[j] = (syn == POS_SYN);
    end

    assign sn_fix = hdr[HDR_W-1 -: SN_W] ^ hit;

    always_comb begin
        if (!par_bad && (syn == '0)) cls = ERR_NONE;
        else if (par_bad)            cls = ERR_SINGLE;
        else                         cls = ERR_MULTI;
    end

endmodule

// File: rtl/aal1_sn_seqtrack.sv
module aal1_sn_seqtrack
    import aal1_sn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [CNT_W-1:0] cnt,
    output logic             seq_err
);

    seq_state_t       st_d, st_q;
    logic [CNT_W-1:0] want;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        want     = st_q.last + 1'b1;
        if (acc) begin
            st_d.err      = st_q.have_ref && (cnt != want);
            st_d.have_ref = 1'b1;
            st_d.last     = cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seq_err = st_q.err;

    p_no_flag_without_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !seq_err);
    p_first_accept_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !st_q.have_ref) |=> !seq_err);
    p_in_order_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && st_q.have_ref && (cnt == want)) |=> !seq_err);

endmodule

// File: rtl/aal1_sn_check.sv
module aal1_sn_check
    import aal1_sn_pkg::*;
#(
    parameter logic [CRC_W:0] GEN_POLY = 4'b1011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_stb,
    input  logic [HDR_W-1:0] in_hdr,
    output logic             o_stb,
    output logic             o_ok,
    output logic             o_fixed,
    output logic             o_ind,
    output logic [CNT_W-1:0] o_cnt,
    output logic             o_seq_err
);

    err_class_e      cls;
    logic [SN_W-1:0] sn_fix;
    logic            accept;
    chk_state_t      st_d, st_q;

    aal1_sn_decode #(.GEN_POLY(GEN_POLY)) u_decode (
        .hdr    (in_hdr),
        .cls    (cls),
        .sn_fix (sn_fix)
    );

    always_comb begin
        accept = in_stb && ((cls == ERR_NONE) ||
                            ((cls == ERR_SINGLE) && (st_q.mode == MODE_REPAIR)));
        st_d       = st_q;
        st_d.stb   = in_stb;
        st_d.ok    = accept;
        st_d.fixed = accept && (cls == ERR_SINGLE);
        if (accept) begin
            st_d.ind = sn_fix[SN_W-1];
            st_d.cnt = sn_fix[CNT_W-1:0];
        end
        if (in_stb) begin
            st_d.mode = (cls == ERR_NONE) ? MODE_REPAIR : MODE_GUARD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    aal1_sn_seqtrack u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (accept),
        .cnt     (sn_fix[CNT_W-1:0]),
        .seq_err (o_seq_err)
    );

    assign o_stb   = st_q.stb;
    assign o_ok    = st_q.ok;
    assign o_fixed = st_q.fixed;
    assign o_ind   = st_q.ind;
    assign o_cnt   = st_q.cnt;

    p_idle_flags_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !o_stb |-> (!o_ok && !o_fixed && !o_seq_err));
    p_clean_accepted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && cls == ERR_NONE) |=> (o_ok && !o_fixed && st_q.mode == MODE_REPAIR));
    p_error_enters_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && cls != ERR_NONE) |=> (st_q.mode == MODE_GUARD));
    p_multi_rejected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && cls == ERR_MULTI) |=> (o_stb && !o_ok));
    p_guard_rejects_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && st_q.mode == MODE_GUARD && cls != ERR_NONE) |=> (o_stb && !o_ok));
    p_fixed_means_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        o_fixed |-> o_ok);
    p_seq_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        o_seq_err |-> o_ok);
    p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(o_cnt) && $stable(o_ind)));

endmodule

// File: tb/aal1_sn_check_tb.sv
module aal1_sn_check_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_stb = 1'b0;
    logic [7:0] in_hdr = '0;
    logic       o_stb, o_ok, o_fixed, o_ind, o_seq_err;
    logic [2:0] o_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    aal1_sn_check u_dut (
        .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_hdr(in_hdr),
        .o_stb(o_stb), .o_ok(o_ok), .o_fixed(o_fixed), .o_ind(o_ind),
        .o_cnt(o_cnt), .o_seq_err(o_seq_err)
    );

    // Reference model state
    bit       m_guard, m_ref;
    bit [2:0] m_last;
    bit       e_stb, e_ok, e_fix, e_ind, e_seq;
    bit [2:0] e_cnt;
    string    t_ok, t_fld, t_seq;

    // R1: check bits by long division with x^3+x+1, parity bit makes ones even
    function automatic bit [2:0] m_crc(input bit [3:0] sn);
        bit [6:0] r;
        r = {sn, 3'b000};
        for (int i = 6; i >= 3; i--) if (r[i]) r = r ^ (7'b0001011 << (i - 3));
        return r[2:0];
    endfunction

    function automatic bit [7:0] m_enc(input bit [3:0] sn);
        bit [6:0] t;
        t = {sn, m_crc(sn)};
        return {t, ^t};
    endfunction

    function automatic bit m_valid(input bit [7:0] o);
        return o == m_enc(o[7:4]);
    endfunction

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_guard = 0; m_ref = 0; m_last = 0;
        e_stb = 0; e_ok = 0; e_fix = 0; e_ind = 0; e_seq = 0; e_cnt = 0;
        t_ok = "R9"; t_fld = "R9"; t_seq = "R9";
    endtask

    task automatic model_step(input bit stb, input bit [7:0] o);
        int cls; bit [3:0] sn; bit acc;
        e_stb = stb; e_ok = 0; e_fix = 0; e_seq = 0;
        t_ok = "R2"; t_seq = "R2"; t_fld = "R10";
        if (stb) begin
            sn = o[7:4];
            if (m_valid(o)) cls = 0;
            else begin
                cls = 2;
                for (int k = 0; k < 8; k++)
                    if (cls == 2 && m_valid(o ^ (8'd1 << k))) begin
                        cls = 1; sn = (o ^ (8'd1 << k)) >> 4;
                    end
            end
            acc = (cls == 0) || (cls == 1 && !m_guard);
            if (cls == 0) t_ok = "R3";
            else if (m_guard) t_ok = "R6";
            else if (cls == 1) t_ok = "R4";
            else t_ok = "R5";
            e_ok = acc; e_fix = acc && cls == 1;
            if (acc) begin
                e_ind = sn[3]; e_cnt = sn[2:0];
                t_fld = (cls == 1) ? "R4" : "R1";
                t_seq = m_ref ? "R7" : "R8";
                e_seq = m_ref && (sn[2:0] != 3'(m_last + 3'd1));
                m_ref = 1; m_last = sn[2:0];
            end else t_seq = "R8";
            m_guard = (cls != 0);
        end
    endtask

    task automatic compare();
        chk(o_stb === e_stb, "R2 o_stb", o_stb, e_stb);
        chk(o_ok === e_ok, {t_ok, " o_ok"}, o_ok, e_ok);
        chk(o_fixed === e_fix, {t_ok, " o_fixed"}, o_fixed, e_fix);
        chk(o_seq_err === e_seq, {t_seq, " o_seq_err"}, o_seq_err, e_seq);
        chk(o_ind === e_ind, {t_fld, " o_ind"}, o_ind, e_ind);
        chk(o_cnt === e_cnt, {t_fld, " o_cnt"}, o_cnt, e_cnt);
    endtask

    // Called at a falling edge; returns at the falling edge after the result registers.
    task automatic tick(input bit stb, input bit [7:0] o);
        in_stb = stb; in_hdr = o;
        model_step(stb, o);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic send(input bit [3:0] sn, input bit [7:0] flip);
        tick(1'b1, m_enc(sn) ^ flip);
    endtask

    task automatic do_reset();
        in_stb = 0; in_hdr = '0; rst_n = 0;
        model_reset();
        @(negedge clk);
        compare();                          // R9 reset state
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare();                          // R9 still quiet after release
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        bit [3:0] c;
        do_reset();
        // R1 R3 R7: clean in-order stream across the wrap, first one R8
        for (int i = 0; i < 10; i++) send(4'((i % 8) | ((i & 1) << 3)), 8'h00);
        // R10: idle cycles hold fields
        tick(0, 8'h00); tick(0, 8'hFF);
        // R7: lost cell (skip) and misinserted (repeat)
        send(4'd4, 0); send(4'd6, 0); send(4'd6, 0); send(4'd7, 0);
        // R4 then R3: every single-bit position repaired in repair state, clean restores
        c = 4'd0;
        for (int k = 0; k < 8; k++) begin
            send(c, 8'd1 << k); c = {c[3], 3'(c[2:0] + 3'd1)};
            send(c, 0);         c = {c[3], 3'(c[2:0] + 3'd1)};
        end
        // R6: single error right after an error is rejected, for every position
        for (int k = 0; k < 8; k++) begin
            send(c, 8'h01 << ((k + 3) % 8)); // repaired, enters guard
            send(c + 1, 8'd1 << k);          // rejected in guard
            send(c + 1, 0);
            c = c + 2;
        end
        // R5: double flips rejected in repair state, then guard rejects single
        send(4'd3, 8'h00);
        send(4'd4, 8'h12); send(4'd4, 8'h40); send(4'd4, 8'h80 | 8'h01);
        send(4'd4, 0);
        // R8: rejected headers do not move the reference
        send(4'd5, 8'h90); send(4'd6, 8'h22); send(4'd6, 0);
        // R8 R9: reset mid-stream, first count arbitrary without flag
        do_reset();
        send(4'd13, 0); send(4'd14, 0); send(4'd9, 0);
        // Random mix against the reference model
        for (int n = 0; n < 4000; n++) begin
            int r; bit [7:0] fl;
            r = $urandom_range(0, 99);
            if (r < 60) c = {c[3] ^ 1'($urandom_range(0, 1)), 3'(c[2:0] + 3'd1)};
            else c = 4'($urandom_range(0, 15));
            r = $urandom_range(0, 99);
            if (r < 55) fl = 0;
            else if (r < 80) fl = 8'd1 << $urandom_range(0, 7);
            else fl = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 9) < 2) tick(0, 8'($urandom_range(0, 255)));
            else send(c, fl);
        end
        finish_run();
    end

endmodule